// File: doc/BRIEF.md
# Averaging Single-Slope Converter Sequencer

This block sequences a single-slope analog-to-digital converter and averages by summing. A 10-bit ramp counter feeds an external DAC, and an external comparator returns a flag once the DAC level rises above the analog input. A start pulse begins a run of eight conversions back to back. The ramp count reached in each conversion is widened to 13 bits and added into an accumulator. After the eighth addition a one-cycle done pulse marks the finished sum.

A single state machine drives three registers. The ramp counter has clear and step controls. The sample counter has clear and step controls and a compare against the last index. The accumulator takes its next value from a two-way select, either zero or the old sum plus the widened count. The sum holds steady between runs, so the host can read it at any time after the done pulse.

Top module: `ramp_avg_adc_ctrl`

## Requirements
- R1: While the active-low reset is asserted, dac_code, result and done are all zero.
- R2: When start is seen while idle, result and dac_code are zero one cycle later. From then on dac_code steps up by one per clock while the comparator flag is low.
- R3: A conversion stops at the first code at which cmp_hi is high, so the count for an input level v below 1023 is v+1. That count is the value added.
- R4: If the ramp reaches code 1023 with cmp_hi still low, the conversion ends there and 1023 is added.
- R5: Each start performs exactly eight conversions. The final result is the sum of the eight counts, each zero-extended from 10 to 13 bits.
- R6: dac_code is back at zero two cycles after the cycle in which the comparator stops the ramp, so every conversion ramps from zero.
- R7: done is high for exactly one cycle. For a steady input with per-conversion count c, it rises 8·(c+2) clock edges after the edge that samples start.
- R8: result keeps its final value until the next accepted start. A start pulse during a run changes neither the result nor the timing of done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run of eight conversions; only honoured while idle |
| cmp_hi | input | 1 | Comparator flag, high once the DAC level exceeds the input |
| dac_code | output | 10 | Ramp count driving the DAC |
| result | output | 13 | Sum of the eight conversion counts |
| done | output | 1 | One-cycle pulse when the sum is complete |

## Verification
Each conversion takes c+2 clock edges: c edges of ramp, one edge to see the flag and one edge to add the count. The edge that samples start clears everything, so dac_code is zero right after it and reads one after the next edge. The bench counts edges from the start edge and samples one time unit after each rising edge. It expects dac_code to equal c after edge c, to be zero again after edge c+2, and done to be high only after edge 8·(c+2). The result is compared once that pulse has passed, and again some cycles later to confirm that it holds.

// File: rtl/ramp_avg_adc_ctrl.sv
module ramp_avg_adc_ctrl #(
  parameter int DAC_W  = 10,
  parameter int ACC_W  = 13,
  parameter int N_SAMP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmp_hi,
  output logic [DAC_W-1:0] dac_code,
  output logic [ACC_W-1:0] result,
  output logic             done
);
  localparam int SMP_W = $clog2(N_SAMP);
  localparam logic [DAC_W-1:0] DAC_MAX = {DAC_W{1'b1}};
  localparam logic [SMP_W-1:0] SMP_LAST = SMP_W'(N_SAMP - 1);
  localparam int ACC_LIM = N_SAMP * ((1 << DAC_W) - 1);

  typedef enum logic [1:0] {S_IDLE, S_RAMP, S_ADD} state_t;

  state_t           state, state_n;
  logic [DAC_W-1:0] dac_q;
  logic [SMP_W-1:0] smp_q;
  logic [ACC_W-1:0] acc_q;
  logic             done_q;

  wire go        = (state == S_IDLE) && start;
  wire ramp_stop = cmp_hi || (dac_q == DAC_MAX);
  wire dac_inc   = (state == S_RAMP) && !ramp_stop;
  wire dac_clr   = go || (state == S_ADD);
  wire smp_inc   = (state == S_ADD);
  wire smp_last  = (smp_q == SMP_LAST);
  wire [ACC_W-1:0] acc_d = go ? '0 : acc_q + {{(ACC_W-DAC_W){1'b0}}, dac_q};
  wire acc_en    = go || (state == S_ADD);

  always_comb begin
    state_n = state;
    case (state)
      S_IDLE:  if (start) state_n = S_RAMP;
      S_RAMP:  if (ramp_stop) state_n = S_ADD;
      S_ADD:   state_n = smp_last ? S_IDLE : S_RAMP;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      dac_q  <= '0;
      smp_q  <= '0;
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      state  <= state_n;
      done_q <= (state == S_ADD) && smp_last;
      if (dac_clr)      dac_q <= '0;
      else if (dac_inc) dac_q <= dac_q + 1'b1;
      if (go)           smp_q <= '0;
      else if (smp_inc) smp_q <= smp_q + 1'b1;
      if (acc_en)       acc_q <= acc_d;
    end
  end

  assign dac_code = dac_q;
  assign result   = acc_q;
  assign done     = done_q;

  p_ramp_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RAMP && !cmp_hi && dac_q != DAC_MAX) |=> (dac_q == $past(dac_q) + 1'b1));

  p_cap_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RAMP && dac_q == DAC_MAX) |=> (state == S_ADD && dac_q == DAC_MAX));

  p_acc_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(acc_q) <= ACC_LIM);

  p_ramp_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ADD) |=> (dac_q == '0));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !start) |=> $stable(acc_q));

  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RAMP && start) |=> (acc_q == $past(acc_q)));
endmodule

// File: tb/ramp_avg_adc_ctrl_bench.sv
`timescale 1ns/1ps
module ramp_avg_adc_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cmp_hi;
  logic [9:0]  dac_code;
  logic [12:0] result;
  logic        done;
  logic [10:0] vin = '0;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;
  assign cmp_hi = ({1'b0, dac_code} > vin);

  ramp_avg_adc_ctrl u_ramp_avg_adc_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_hi(cmp_hi),
    .dac_code(dac_code), .result(result), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    #1;
    chk("R1 dac_code in reset", int'(dac_code), 0);
    chk("R1 result in reset", int'(result), 0);
    chk("R1 done in reset", int'(done), 0);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_run(input int level, input bit poke);
    int c = (level + 1 > 1023) ? 1023 : level + 1;
    int t_done = 8 * (c + 2);
    int done_hits = 0;
    int done_edge = -1;
    vin = 11'(level);
    @(negedge clk) start = 1'b1;
    @(posedge clk) #1;
    chk("R2 dac_code zero after start", int'(dac_code), 0);
    chk("R2 result cleared after start", int'(result), 0);
    for (int k = 1; k <= t_done + 2; k++) begin
      @(negedge clk) start = poke && (k == 5);
      @(posedge clk) #1;
      if (k == 1) chk("R2 first ramp step", int'(dac_code), 1);
      if (k == c) chk(c == 1023 ? "R4 ramp capped" : "R3 ramp stop count", int'(dac_code), c);
      if (k == c + 2) chk("R6 ramp back to zero", int'(dac_code), 0);
      if (done) begin
        done_hits++;
        done_edge = k;
      end
    end
    chk("R7 done pulse count", done_hits, 1);
    chk("R7 done edge", done_edge, t_done);
    chk(poke ? "R8 busy start ignored, sum" : (c == 1023 ? "R4 capped sum" : "R5 sum of eight"),
        int'(result), 8 * c);
    repeat (10) @(posedge clk);
    #1;
    chk("R8 result holds", int'(result), 8 * c);
  endtask

  task automatic t_reset_midrun();
    vin = 11'd300;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (40) @(negedge clk);
    t_reset();
  endtask

  task automatic finish_up();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    t_reset();
    t_run(0, 1'b0);
    t_run(100, 1'b0);
    t_run(57, 1'b1);
    t_run(1022, 1'b0);
    t_run(2000, 1'b0);
    t_reset_midrun();
    t_run(9, 1'b0);
    finish_up();
  end
endmodule